// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The controller gathers 32 level-sensitive interrupt lines from peripherals and turns them into two processor requests: a fast request line and a normal request line. Software gives each line an enable bit and a class bit that routes it to one of the two outputs. Lines routed to the normal request also get a 4-bit priority level and a handler address held in a per-source table.

When the processor takes the normal request, its handler reads the vector register. That read returns the table entry of the most urgent pending source and freezes it for the rest of the service. The most urgent source is the one with the lowest level number; on a tie the lowest source index wins. While a service is open, only a source whose level number is strictly lower than the one being served can bring a new vector forward. A write of any value to the vector register ends the service. If no enabled normal-class source is pending, the vector register returns a programmable default address. A register port also exposes the raw inputs and the two masked request views.

Register map (word addresses on an 8-bit address):
- 0x00 enable
- 0x01 class (1 = fast)
- 0x02 raw
- 0x03 masked normal status
- 0x04 masked fast status
- 0x05 default vector
- 0x06 vector / end-of-service
- 0x40+n handler address for source n
- 0x80+n priority level for source n

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0, both status views read 0, and `fiq_o` and `irq_o` are low.
- R2: Source inputs are registered once. The raw view at 0x02 shows the inputs as sampled at the previous clock edge, whatever the enable and class settings are.
- R3: `fiq_o` is high exactly when some source is high, enabled and has class bit 1. The fast status view at 0x04 is the raw view AND enable AND class.
- R4: `irq_o` is high exactly when some source is high, enabled and has class bit 0. The normal status view at 0x03 is the raw view AND enable AND NOT class.
- R5: Reading 0x06 with no open service returns the handler address of the pending normal-class source that has the lowest level number.
- R6: Among pending sources at the same level, the lowest source index wins.
- R7: Reading 0x06 with no pending normal-class source and no open service returns the default vector held at 0x05.
- R8: A read of 0x06 that returns a source's address opens a service. From then until the end-of-service write, reads of 0x06 return that same address, even if the source drops or sources of equal or lower urgency arrive.
- R9: While a service is open, a pending source whose level number is strictly lower than the served level wins the next read of 0x06. That read latches the new source's address and level.
- R10: Any write to 0x06 closes the open service, and later reads of 0x06 follow R5 and R7 again.
- R11: A source that is disabled, or that has class bit 1, never supplies the vector.
- R12: Priority slots keep only their low 4 bits and read back with the upper bits zero. Handler slots keep the full 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 32 | Level-sensitive interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of 0x06 has side effects) |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| fiq_o | output | 1 | Fast request to the processor |
| irq_o | output | 1 | Normal request to the processor |

## Verification
The bench places two sources on one level with a third on a less urgent level. A design that compared levels without the index tie-break would return the higher-index address. While a service is open, it drops the served source and adds a same-level source. A design that did not freeze the vector would jump to the new address. It then raises a more urgent source and expects preemption, which catches a vector that stays frozen too hard or uses a less-or-equal comparison. Finally it checks the default vector while disabled and fast-class lines are high, which catches masking that leaks either kind of line into the vector.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int PW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            fiq_o,
  output logic            irq_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] src_q, en_q, cls_q;
  logic [DW-1:0]   tab_q [NSRC];
  logic [PW-1:0]   lvl_q [NSRC];
  logic [DW-1:0]   dflt_q, vec_q;
  logic [PW-1:0]   svc_lvl_q;
  logic            in_svc_q;

  wire [NSRC-1:0] irq_pend = src_q & en_q & ~cls_q;
  wire [NSRC-1:0] fiq_pend = src_q & en_q & cls_q;
  assign irq_o = |irq_pend;
  assign fiq_o = |fiq_pend;

  logic          found;
  logic [IW-1:0] win;
  logic [PW-1:0] win_lvl;
  always_comb begin
    found   = 1'b0;
    win     = '0;
    win_lvl = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (irq_pend[i] && (!found || lvl_q[i] <= win_lvl)) begin
        found   = 1'b1;
        win     = IW'(i);
        win_lvl = lvl_q[i];
      end
    end
  end

  wire preempt = found && (!in_svc_q || win_lvl < svc_lvl_q);
  wire [DW-1:0] vec_view = preempt ? tab_q[win] : (in_svc_q ? vec_q : dflt_q);

  wire           a_vec   = reg_addr == 8'h06;
  wire           in_win  = reg_addr[5:0] < 6'(NSRC);
  wire           a_tab   = reg_addr[7:6] == 2'b01 && in_win;
  wire           a_lvl   = reg_addr[7:6] == 2'b10 && in_win;
  wire [IW-1:0]  slot    = reg_addr[IW-1:0];
  wire           eoi     = reg_wr && a_vec;
  wire           take    = reg_rd && a_vec && preempt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      en_q      <= '0;
      cls_q     <= '0;
      dflt_q    <= '0;
      vec_q     <= '0;
      svc_lvl_q <= '0;
      in_svc_q  <= 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        tab_q[i] <= '0;
        lvl_q[i] <= '0;
      end
    end else begin
      src_q <= src_i;
      if (reg_wr) begin
        case (reg_addr)
          8'h00:   en_q   <= reg_wdata[NSRC-1:0];
          8'h01:   cls_q  <= reg_wdata[NSRC-1:0];
          8'h05:   dflt_q <= reg_wdata;
          default: ;
        endcase
        if (a_tab) tab_q[slot] <= reg_wdata;
        if (a_lvl) lvl_q[slot] <= reg_wdata[PW-1:0];
      end
      if (eoi) begin
        in_svc_q <= 1'b0;
      end else if (take) begin
        in_svc_q  <= 1'b1;
        vec_q     <= tab_q[win];
        svc_lvl_q <= win_lvl;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00:   reg_rdata = DW'(en_q);
      8'h01:   reg_rdata = DW'(cls_q);
      8'h02:   reg_rdata = DW'(src_q);
      8'h03:   reg_rdata = DW'(irq_pend);
      8'h04:   reg_rdata = DW'(fiq_pend);
      8'h05:   reg_rdata = dflt_q;
      8'h06:   reg_rdata = vec_view;
      default: begin
        if (a_tab) reg_rdata = tab_q[slot];
        if (a_lvl) reg_rdata = DW'(lvl_q[slot]);
      end
    endcase
  end
endmodule

module irq_vector_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic [NSRC-1:0] src_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] cls_q,
  input logic            fiq_o,
  input logic            irq_o,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [7:0]      reg_addr,
  input logic            in_svc_q,
  input logic [DW-1:0]   vec_q
);
  // R2
  raw_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> src_q == $past(src_i));
  // R3
  fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (en_q & cls_q) != '0);
  // R4
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q & ~cls_q) != '0);
  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_q && !((reg_wr || reg_rd) && reg_addr == 8'h06) |=> in_svc_q && $stable(vec_q));
  // R10
  eoi_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 8'h06 |=> !in_svc_q);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .src_q(src_q), .en_q(en_q),
  .cls_q(cls_q), .fiq_o(fiq_o), .irq_o(irq_o), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .in_svc_q(in_svc_q), .vec_q(vec_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fiq_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 fiq_o", 32'(fiq_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    rd(8'h00, d); chk("R1 enable", d, 0);
    rd(8'h01, d); chk("R1 class", d, 0);
    rd(8'h05, d); chk("R1 default", d, 0);
    rd(8'h03, d); chk("R1 irq status", d, 0);
    rd(8'h84, d); chk("R1 level slot", d, 0);
  endtask

  task automatic t_raw;
    logic [31:0] d;
    drive(32'h0000_0011);
    rd(8'h02, d); chk("R2 raw view", d, 32'h0000_0011);
    chk("R4 irq_o while disabled", 32'(irq_o), 0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(8'h00, 32'h0000_0011);
    wr(8'h01, 32'h0000_0010);
    chk("R3 fiq_o", 32'(fiq_o), 1);
    chk("R4 irq_o", 32'(irq_o), 1);
    rd(8'h03, d); chk("R4 irq status", d, 32'h0000_0001);
    rd(8'h04, d); chk("R3 fiq status", d, 32'h0000_0010);
  endtask

  task automatic t_default;
    logic [31:0] d;
    wr(8'h05, 32'hDEAD_0000);
    wr(8'h00, 32'h0000_0010);
    chk("R4 irq_o low with only fast line", 32'(irq_o), 0);
    rd(8'h06, d); chk("R7 R11 default vector", d, 32'hDEAD_0000);
    rd(8'h06, d); chk("R7 default again", d, 32'hDEAD_0000);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    drive(32'h0);
    wr(8'h01, 32'h0);
    for (int i = 0; i < 32; i++) wr(8'h40 + 8'(i), 32'h1000 + 32'(i) * 4);
    wr(8'h84, 3);
    wr(8'h8E, 1);
    wr(8'h94, 1);
    wr(8'h82, 1);
    wr(8'h89, 0);
    wr(8'h00, (32'h1 << 4) | (32'h1 << 14) | (32'h1 << 20) | (32'h1 << 9) | (32'h1 << 2));
    drive((32'h1 << 4) | (32'h1 << 14) | (32'h1 << 20));
    rd(8'h06, d); chk("R5 R6 winner slot 14", d, 32'h1038);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    drive((32'h1 << 4) | (32'h1 << 20) | (32'h1 << 2));
    rd(8'h06, d); chk("R8 held after drop and equal arrival", d, 32'h1038);
    chk("R4 irq_o during service", 32'(irq_o), 1);
    drive((32'h1 << 4) | (32'h1 << 20) | (32'h1 << 2) | (32'h1 << 9));
    rd(8'h06, d); chk("R9 preempt by level 0", d, 32'h1024);
    drive((32'h1 << 4) | (32'h1 << 20) | (32'h1 << 2));
    rd(8'h06, d); chk("R8 held after preempting source drops", d, 32'h1024);
  endtask

  task automatic t_eoi;
    logic [31:0] d;
    wr(8'h06, 32'h0);
    rd(8'h06, d); chk("R10 R6 live after end of service", d, 32'h1008);
    wr(8'h06, 32'h0);
    drive(32'h0);
    rd(8'h06, d); chk("R10 R7 default after close", d, 32'hDEAD_0000);
  endtask

  task automatic t_width;
    logic [31:0] d;
    wr(8'h85, 32'hFFFF_FFFF);
    rd(8'h85, d); chk("R12 level slot width", d, 32'h0000_000F);
    rd(8'h47, d); chk("R12 handler slot", d, 32'h101C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_raw;
    t_route;
    t_default;
    t_prio;
    t_hold;
    t_eoi;
    t_width;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule